// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in front of the ALU in a five-stage in-order pipeline. It picks each of the two execute-stage operands from one of three places: the value read from the register file, the ALU result held in the memory-stage pipeline register, or the result held in the writeback-stage pipeline register. The choice rests on comparing the execute-stage source register numbers with the destinations of the two older instructions still in flight. When both older instructions write the same register, the younger one wins. Register zero is never forwarded.

A second path serves a load followed directly by a store of the loaded register. In the cycle the store is in the memory stage, the load data held in the writeback stage replaces the store's write data. The unit is purely combinational. It does not stall for load-use hazards, resolve branches, compute ALU results or hold any pipeline register.

Top module: `opfwd_unit`

## Requirements
- R1: `sel_a`/`sel_b` take only the codes 0 (register-file value), 1 (writeback-stage result) and 2 (memory-stage result). `opa_out`/`opb_out` always equal the source that the code names.
- R2: An operand gets code 2 when the memory-stage instruction writes a register (`mem_wr_en`=1) and its destination equals that operand's nonzero source index.
- R3: An operand gets code 1 when the writeback-stage instruction writes the operand's nonzero source index and the memory-stage instruction does not write that same register.
- R4: When both older instructions write the operand's source register, code 2 (the newer result) is chosen.
- R5: A source index of 0 always gets code 0 and the register-file value, even when an older instruction names register 0 as its destination.
- R6: A destination whose write enable is 0 never causes forwarding.
- R7: `st_fwd` is 1 exactly when `wb_is_load`=1, `wb_wr_en`=1, `wb_dst_idx`≠0, `mem_is_store`=1 and `mem_st_rt_idx`=`wb_dst_idx`. `st_data_out` is then `wb_res`.
- R8: When `st_fwd` is 0, `st_data_out` equals `mem_st_data`. A non-load writeback, a non-store memory-stage instruction, a mismatched index and register 0 each keep it there.
- R9: Operands A and B are selected independently. One can take code 1 while the other takes code 2 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_idx | input | 5 | Execute-stage first source register number |
| ex_rt_idx | input | 5 | Execute-stage second source register number |
| ex_rs_val | input | 32 | Register-file value for the first source |
| ex_rt_val | input | 32 | Register-file value for the second source |
| mem_dst_idx | input | 5 | Memory-stage destination register number |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_alu_res | input | 32 | Memory-stage ALU result |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_st_rt_idx | input | 5 | Register number of the store's data source |
| mem_st_data | input | 32 | Store write data carried in the pipeline register |
| wb_dst_idx | input | 5 | Writeback-stage destination register number |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| wb_is_load | input | 1 | Writeback-stage instruction is a load |
| wb_res | input | 32 | Writeback-stage result (ALU or load data) |
| opa_out | output | 32 | Selected first ALU operand |
| opb_out | output | 32 | Selected second ALU operand |
| sel_a | output | 2 | Select code for the first operand |
| sel_b | output | 2 | Select code for the second operand |
| st_fwd | output | 1 | Load data replaces the store write data |
| st_data_out | output | 32 | Write data to the data memory |

## Verification
Every result of this unit is due in the same cycle as the stimulus, because no register lies between the pipeline-register inputs and the selects, operands or store data. The bench applies each vector just after a rising clock edge and samples all outputs at the following falling edge, half a period later. All inputs have settled by then, and no later edge has moved them. The worked subtraction example is replayed as two consecutive vectors. The first takes -2 from the memory stage and the second takes it from the writeback stage, matching how the result moves one stage per cycle.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
    typedef enum logic [1:0] {
        FSEL_RF  = 2'd0,
        FSEL_WB  = 2'd1,
        FSEL_MEM = 2'd2
    } fwd_sel_e;
endpackage

// File: rtl/opfwd_src_sel.sv
module opfwd_src_sel
    import opfwd_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [IDX_W-1:0]  mem_dst,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [IDX_W-1:0]  wb_dst,
    input  logic              wb_we,
    input  logic [DATA_W-1:0] wb_val,
    output fwd_sel_e          sel,
    output logic [DATA_W-1:0] val
);
    typedef struct packed {
        logic     hit_mem;
        logic     hit_wb;
        fwd_sel_e sel;
    } dec_t;

    dec_t dec_d;

    always_comb begin
        dec_d = '0;
        dec_d.hit_mem = mem_we && (mem_dst == src_idx) && (src_idx != '0);
        dec_d.hit_wb  = wb_we && (wb_dst == src_idx) && (src_idx != '0);
        if (dec_d.hit_mem) begin
            dec_d.sel = FSEL_MEM;
        end else if (dec_d.hit_wb) begin
            dec_d.sel = FSEL_WB;
        end else begin
            dec_d.sel = FSEL_RF;
        end
    end

    assign sel = dec_d.sel;

    always_comb begin
        unique case (dec_d.sel)
            FSEL_MEM: val = mem_val;
            FSEL_WB:  val = wb_val;
            default:  val = rf_val;
        endcase
    end
endmodule

// File: rtl/opfwd_store_path.sv
module opfwd_store_path #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              mem_is_store,
    input  logic [IDX_W-1:0]  mem_st_rt_idx,
    input  logic [DATA_W-1:0] mem_st_data,
    input  logic [IDX_W-1:0]  wb_dst_idx,
    input  logic              wb_wr_en,
    input  logic              wb_is_load,
    input  logic [DATA_W-1:0] wb_res,
    output logic              st_fwd,
    output logic [DATA_W-1:0] st_data_out
);
    typedef struct packed {
        logic load_live;
        logic idx_match;
        logic take;
    } st_dec_t;

    st_dec_t st_d;

    always_comb begin
        st_d.load_live = wb_is_load && wb_wr_en && (wb_dst_idx != '0);
        st_d.idx_match = (mem_st_rt_idx == wb_dst_idx);
        st_d.take      = st_d.load_live && mem_is_store && st_d.idx_match;
    end

    assign st_fwd      = st_d.take;
    assign st_data_out = st_d.take ? wb_res : mem_st_data;
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]  ex_rs_idx,
    input  logic [IDX_W-1:0]  ex_rt_idx,
    input  logic [DATA_W-1:0] ex_rs_val,
    input  logic [DATA_W-1:0] ex_rt_val,
    input  logic [IDX_W-1:0]  mem_dst_idx,
    input  logic              mem_wr_en,
    input  logic [DATA_W-1:0] mem_alu_res,
    input  logic              mem_is_store,
    input  logic [IDX_W-1:0]  mem_st_rt_idx,
    input  logic [DATA_W-1:0] mem_st_data,
    input  logic [IDX_W-1:0]  wb_dst_idx,
    input  logic              wb_wr_en,
    input  logic              wb_is_load,
    input  logic [DATA_W-1:0] wb_res,
    output logic [DATA_W-1:0] opa_out,
    output logic [DATA_W-1:0] opb_out,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic              st_fwd,
    output logic [DATA_W-1:0] st_data_out
);
    localparam int N_OPS = 2;

    logic [N_OPS-1:0][IDX_W-1:0]  src_idx;
    logic [N_OPS-1:0][DATA_W-1:0] src_rf;
    logic [N_OPS-1:0][DATA_W-1:0] src_out;
    fwd_sel_e                     src_sel [N_OPS];

    assign src_idx[0] = ex_rs_idx;
    assign src_idx[1] = ex_rt_idx;
    assign src_rf[0]  = ex_rs_val;
    assign src_rf[1]  = ex_rt_val;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        opfwd_src_sel #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_sel (
            .src_idx (src_idx[g]),
            .rf_val  (src_rf[g]),
            .mem_dst (mem_dst_idx),
            .mem_we  (mem_wr_en),
            .mem_val (mem_alu_res),
            .wb_dst  (wb_dst_idx),
            .wb_we   (wb_wr_en),
            .wb_val  (wb_res),
            .sel     (src_sel[g]),
            .val     (src_out[g])
        );
    end

    assign opa_out = src_out[0];
    assign opb_out = src_out[1];
    assign sel_a   = src_sel[0];
    assign sel_b   = src_sel[1];

    opfwd_store_path #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_st (
        .mem_is_store  (mem_is_store),
        .mem_st_rt_idx (mem_st_rt_idx),
        .mem_st_data   (mem_st_data),
        .wb_dst_idx    (wb_dst_idx),
        .wb_wr_en      (wb_wr_en),
        .wb_is_load    (wb_is_load),
        .wb_res        (wb_res),
        .st_fwd        (st_fwd),
        .st_data_out   (st_data_out)
    );
endmodule

// File: rtl/opfwd_unit_chk.sv
module opfwd_unit_chk #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 32
) (
    input logic [IDX_W-1:0]  ex_rs_idx,
    input logic [IDX_W-1:0]  ex_rt_idx,
    input logic [DATA_W-1:0] ex_rs_val,
    input logic [DATA_W-1:0] ex_rt_val,
    input logic [IDX_W-1:0]  mem_dst_idx,
    input logic              mem_wr_en,
    input logic [DATA_W-1:0] mem_alu_res,
    input logic              mem_is_store,
    input logic [IDX_W-1:0]  mem_st_rt_idx,
    input logic [DATA_W-1:0] mem_st_data,
    input logic [IDX_W-1:0]  wb_dst_idx,
    input logic              wb_wr_en,
    input logic              wb_is_load,
    input logic [DATA_W-1:0] wb_res,
    input logic [DATA_W-1:0] opa_out,
    input logic [DATA_W-1:0] opb_out,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic              st_fwd,
    input logic [DATA_W-1:0] st_data_out
);
    always_comb begin
        assert_legal_code_R1: assert (sel_a != 2'd3 && sel_b != 2'd3);
        assert_opa_matches_code_R1: assert (
            (sel_a == 2'd0 && opa_out == ex_rs_val) ||
            (sel_a == 2'd1 && opa_out == wb_res) ||
            (sel_a == 2'd2 && opa_out == mem_alu_res));
        assert_mem_hit_a_R2: assert (!(mem_wr_en && ex_rs_idx != '0 &&
                                       mem_dst_idx == ex_rs_idx) || sel_a == 2'd2);
        assert_mem_hit_b_R4: assert (!(mem_wr_en && ex_rt_idx != '0 &&
                                       mem_dst_idx == ex_rt_idx) || sel_b == 2'd2);
        assert_zero_src_R5: assert ((ex_rs_idx != '0 || sel_a == 2'd0) &&
                                    (ex_rt_idx != '0 || sel_b == 2'd0));
        assert_no_enable_R6: assert (mem_wr_en || wb_wr_en ||
                                     (sel_a == 2'd0 && sel_b == 2'd0));
        assert_store_data_R7: assert (!st_fwd || (st_data_out == wb_res &&
                                      wb_is_load && mem_is_store));
        assert_store_hold_R8: assert (st_fwd || st_data_out == mem_st_data);
    end
endmodule

bind opfwd_unit opfwd_unit_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/opfwd_unit_test.sv
module opfwd_unit_test;
    localparam int IW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [IW-1:0] ex_rs_idx, ex_rt_idx, mem_dst_idx, mem_st_rt_idx, wb_dst_idx;
    logic [DW-1:0] ex_rs_val, ex_rt_val, mem_alu_res, mem_st_data, wb_res;
    logic          mem_wr_en, mem_is_store, wb_wr_en, wb_is_load;
    logic [DW-1:0] opa_out, opb_out, st_data_out;
    logic [1:0]    sel_a, sel_b;
    logic          st_fwd;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    opfwd_unit #(.IDX_W(IW), .DATA_W(DW)) uut (.*);

    typedef struct packed {
        logic [IW-1:0] rs;
        logic [IW-1:0] rt;
        logic [IW-1:0] md;
        logic          mwe;
        logic [IW-1:0] wd;
        logic          wwe;
        logic [1:0]    ea;
        logic [1:0]    eb;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{5'd2,  5'd5,  5'd2,  1'b1, 5'd0,  1'b0, 2'd2, 2'd0},  // R2
        '{5'd6,  5'd2,  5'd12, 1'b1, 5'd2,  1'b1, 2'd0, 2'd1},  // R3
        '{5'd1,  5'd1,  5'd1,  1'b1, 5'd1,  1'b1, 2'd2, 2'd2},  // R4
        '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'd0, 2'd0},  // R5
        '{5'd3,  5'd4,  5'd3,  1'b0, 5'd4,  1'b0, 2'd0, 2'd0},  // R6
        '{5'd7,  5'd8,  5'd8,  1'b1, 5'd7,  1'b1, 2'd1, 2'd2},  // R9
        '{5'd9,  5'd9,  5'd9,  1'b0, 5'd9,  1'b1, 2'd1, 2'd1},  // R3 / R6
        '{5'd31, 5'd30, 5'd30, 1'b1, 5'd31, 1'b1, 2'd1, 2'd2},  // R9
        '{5'd10, 5'd11, 5'd12, 1'b1, 5'd13, 1'b1, 2'd0, 2'd0},  // R1
        '{5'd0,  5'd5,  5'd0,  1'b1, 5'd5,  1'b1, 2'd0, 2'd1}   // R5
    };

    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf,
                                           input logic [DW-1:0] m, input logic [DW-1:0] w);
        return (s == 2'd2) ? m : (s == 2'd1) ? w : rf;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ex_rs_idx = '0; ex_rt_idx = '0; ex_rs_val = 32'd100; ex_rt_val = 32'd100;
        mem_dst_idx = '0; mem_wr_en = 1'b0; mem_alu_res = 32'hA5A5_0000;
        mem_is_store = 1'b0; mem_st_rt_idx = '0; mem_st_data = 32'h5757_0000;
        wb_dst_idx = '0; wb_wr_en = 1'b0; wb_is_load = 1'b0; wb_res = 32'h3C3C_0000;
    endtask

    task automatic store_case(input string req, input logic ld, input logic st,
                              input logic [IW-1:0] wd, input logic [IW-1:0] srt,
                              input logic exp_fwd);
        @(posedge clk);
        idle();
        wb_is_load = ld; wb_wr_en = 1'b1; wb_dst_idx = wd; wb_res = 32'hDEAD_0001;
        mem_is_store = st; mem_st_rt_idx = srt; mem_st_data = 32'hBEEF_0002;
        @(negedge clk);
        chk(req, {31'd0, st_fwd}, {31'd0, exp_fwd});
        chk(req, st_data_out, exp_fwd ? 32'hDEAD_0001 : 32'hBEEF_0002);
    endtask

    initial begin
        idle();
        @(negedge clk);
        // quiet inputs: no forwarding anywhere (R1, R8)
        chk("R1 quiet sel_a", {30'd0, sel_a}, 32'd0);
        chk("R1 quiet opa", opa_out, 32'd100);
        chk("R8 quiet store", st_data_out, 32'h5757_0000);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            ex_rs_idx = TBL[i].rs; ex_rt_idx = TBL[i].rt;
            ex_rs_val = 32'd100 + 32'(TBL[i].rs); ex_rt_val = 32'd100 + 32'(TBL[i].rt);
            mem_dst_idx = TBL[i].md; mem_wr_en = TBL[i].mwe;
            mem_alu_res = 32'h1000_0000 + 32'(i);
            wb_dst_idx = TBL[i].wd; wb_wr_en = TBL[i].wwe;
            wb_res = 32'h2000_0000 + 32'(i);
            @(negedge clk);
            chk("R2/R3/R4 sel_a", {30'd0, sel_a}, {30'd0, TBL[i].ea});
            chk("R2/R3/R4 sel_b", {30'd0, sel_b}, {30'd0, TBL[i].eb});
            chk("R1 opa", opa_out, pick(TBL[i].ea, ex_rs_val, mem_alu_res, wb_res));
            chk("R1 opb", opb_out, pick(TBL[i].eb, ex_rt_val, mem_alu_res, wb_res));
        end

        // worked example: registers hold index+100, sub yields -2 into reg 2
        @(posedge clk);
        idle();
        ex_rs_idx = 5'd2; ex_rt_idx = 5'd5; ex_rs_val = 32'd102; ex_rt_val = 32'd105;
        mem_dst_idx = 5'd2; mem_wr_en = 1'b1; mem_alu_res = -32'sd2;
        @(negedge clk);
        chk("R2 example and-operand", opa_out, -32'sd2);
        chk("R2 example and-other", opb_out, 32'd105);
        @(posedge clk);
        ex_rs_idx = 5'd6; ex_rt_idx = 5'd2; ex_rs_val = 32'd106; ex_rt_val = 32'd102;
        mem_dst_idx = 5'd12; mem_wr_en = 1'b1; mem_alu_res = 32'd104;
        wb_dst_idx = 5'd2; wb_wr_en = 1'b1; wb_res = -32'sd2;
        @(negedge clk);
        chk("R3 example or-operand", opb_out, -32'sd2);
        chk("R3 example or-other", opa_out, 32'd106);

        // store data path
        store_case("R7 load->store", 1'b1, 1'b1, 5'd1, 5'd1, 1'b1);
        chk("R7 operands untouched", opa_out, 32'd100);
        store_case("R8 reg zero", 1'b1, 1'b1, 5'd0, 5'd0, 1'b0);
        store_case("R8 not a load", 1'b0, 1'b1, 5'd1, 5'd1, 1'b0);
        store_case("R8 not a store", 1'b1, 1'b0, 5'd1, 5'd1, 1'b0);
        store_case("R8 index mismatch", 1'b1, 1'b1, 5'd1, 5'd3, 1'b0);
        store_case("R7 high index", 1'b1, 1'b1, 5'd31, 5'd31, 1'b1);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule